// File: doc/BRIEF.md
# Dimension-Order Mesh Route Computation

This block decides, for one switch of a two-dimensional mesh without wraparound links, which output a packet must take next. It receives the destination coordinates from a packet header over a valid/ready handshake. It compares them with the switch's own coordinates, which arrive on static inputs, and registers a one-hot select naming one of five outputs. The five outputs are local ejection, +X, -X, +Y and -Y.

The X distance is always brought to zero before Y is considered. A route therefore depends only on where a packet starts and where it is going. It never turns back in either axis, and no dependency cycle can form among the mesh channels.

Back-pressure works as a single registered slot. A header is taken only while `hdr_ready` is high, and `hdr_ready` is high whenever the slot is empty or the downstream side is taking its contents in the same cycle. While `sel_valid` is high and `sel_ready` is low, the select is frozen, and any header offered upstream waits.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `sel_valid` is low and `hdr_ready` is high.
- R2: A header whose destination X is greater than `node_x` yields `sel_port` bit 1 (+X).
- R3: A header whose destination X is less than `node_x` yields `sel_port` bit 2 (-X), whatever the Y values.
- R4: A header with destination X equal to `node_x` and destination Y greater than `node_y` yields bit 3 (+Y).
- R5: A header with destination X equal to `node_x` and destination Y less than `node_y` yields bit 4 (-Y).
- R6: A header whose coordinates equal both node coordinates yields bit 0 (local ejection).
- R7: While `sel_valid` is high, exactly one bit of `sel_port` is set.
- R8: The select for a header accepted at a clock edge is presented, with `sel_valid` high, right after that edge.
- R9: While `sel_valid` is high and `sel_ready` is low, `sel_valid` stays high and `sel_port` does not change, even when a new header is offered.
- R10: `hdr_ready` equals the value of NOT `sel_valid` OR `sel_ready`. A held select and a new header can therefore be exchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | CW | Own X coordinate (static) |
| node_y | input | CW | Own Y coordinate (static) |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted when high with hdr_valid |
| hdr_dst_x | input | CW | Destination X coordinate |
| hdr_dst_y | input | CW | Destination Y coordinate |
| sel_valid | output | 1 | Select present |
| sel_ready | input | 1 | Downstream takes the select |
| sel_port | output | 5 | One-hot output select: 0 local, 1 +X, 2 -X, 3 +Y, 4 -Y |

## Verification
The case hardest to reach from the ports is a new header arriving while an earlier select is held against back-pressure. The held select must not be replaced, and the header must be taken in the very cycle the held select drains. The bench holds `sel_ready` low with a second header already waiting, watches the frozen output for several cycles, and then releases both on one edge. Every X/Y ordering is covered by sweeping all node positions against all destinations of a 4-by-4 mesh.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  localparam int PORT_N = 5;
  typedef enum int unsigned {
    P_LOCAL = 0,
    P_XPOS  = 1,
    P_XNEG  = 2,
    P_YPOS  = 3,
    P_YNEG  = 4
  } port_idx_e;
  typedef logic [PORT_N-1:0] port_vec_t;
endpackage

// File: rtl/axis_compare.sv
module axis_compare #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] here,
  input  logic [CW-1:0] there,
  output logic          ahead,
  output logic          behind
);
  always_comb begin
    ahead  = there > here;
    behind = there < here;
  end

  always_comb begin
    assert (!(ahead && behind)) else $error("axis_compare: both directions flagged");
  end
endmodule

// File: rtl/port_select.sv
module port_select
  import mesh_route_pkg::*;
(
  input  logic      x_ahead,
  input  logic      x_behind,
  input  logic      y_ahead,
  input  logic      y_behind,
  output port_vec_t port
);
  always_comb begin
    port = '0;
    if (x_ahead)       port[P_XPOS]  = 1'b1;
    else if (x_behind) port[P_XNEG]  = 1'b1;
    else if (y_ahead)  port[P_YPOS]  = 1'b1;
    else if (y_behind) port[P_YNEG]  = 1'b1;
    else               port[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/route_stage.sv
module route_stage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
  import mesh_route_pkg::*;
#(
  parameter int K  = 4,
  parameter int CW = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     node_x,
  input  logic [CW-1:0]     node_y,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [CW-1:0]     hdr_dst_x,
  input  logic [CW-1:0]     hdr_dst_y,
  output logic              sel_valid,
  input  logic              sel_ready,
  output logic [PORT_N-1:0] sel_port
);
  localparam int DIMS = 2;

  logic [DIMS-1:0][CW-1:0] here_c, there_c;
  logic [DIMS-1:0]         ahead, behind;
  port_vec_t               next_port;

  assign here_c[0]  = node_x;
  assign here_c[1]  = node_y;
  assign there_c[0] = hdr_dst_x;
  assign there_c[1] = hdr_dst_y;

  for (genvar d = 0; d < DIMS; d++) begin : g_axis
    axis_compare #(.CW(CW)) u_cmp (
      .here  (here_c[d]),
      .there (there_c[d]),
      .ahead (ahead[d]),
      .behind(behind[d])
    );
  end

  port_select u_sel (
    .x_ahead (ahead[0]),
    .x_behind(behind[0]),
    .y_ahead (ahead[1]),
    .y_behind(behind[1]),
    .port    (next_port)
  );

  route_stage #(.W(PORT_N)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (hdr_valid),
    .in_ready (hdr_ready),
    .in_data  (next_port),
    .out_valid(sel_valid),
    .out_ready(sel_ready),
    .out_data (sel_port)
  );

  logic hdr_fire;
  assign hdr_fire = hdr_valid && hdr_ready;

  assert_plus_x_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && (hdr_dst_x > node_x) |=> sel_valid && sel_port[P_XPOS]);
  assert_minus_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && (hdr_dst_x < node_x) |=> sel_valid && sel_port[P_XNEG]);
  assert_plus_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && (hdr_dst_x == node_x) && (hdr_dst_y > node_y) |=> sel_port[P_YPOS]);
  assert_minus_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && (hdr_dst_x == node_x) && (hdr_dst_y < node_y) |=> sel_port[P_YNEG]);
  assert_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire && (hdr_dst_x == node_x) && (hdr_dst_y == node_y) |=> sel_port[P_LOCAL]);
  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> $countones(sel_port) == 1);
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> sel_valid);
  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> hdr_ready);
endmodule

// File: tb/mesh_route_unit_bench.sv
module mesh_route_unit_bench;
  localparam int K  = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] node_x = '0, node_y = '0;
  logic          hdr_valid = 1'b0;
  logic          hdr_ready;
  logic [CW-1:0] hdr_dst_x = '0, hdr_dst_y = '0;
  logic          sel_valid;
  logic          sel_ready = 1'b1;
  logic [4:0]    sel_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mesh_route_unit #(.K(K)) u_mesh_route_unit (
    .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_port(sel_port)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expect_port(input int nx, ny, dx, dy);
    if (dx > nx) return 5'b00010;
    if (dx < nx) return 5'b00100;
    if (dy > ny) return 5'b01000;
    if (dy < ny) return 5'b10000;
    return 5'b00001;
  endfunction

  function automatic string req_of(input int nx, ny, dx, dy);
    if (dx > nx) return "R2";
    if (dx < nx) return "R3";
    if (dy > ny) return "R4";
    if (dy < ny) return "R5";
    return "R6";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [4:0] held, nxt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0, "R1", sel_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_valid == 1'b0 && hdr_ready == 1'b1, "R1", {sel_valid, hdr_ready}, 1);

    // Exhaustive sweep: R2..R8
    for (int nx = 0; nx < K; nx++)
      for (int ny = 0; ny < K; ny++)
        for (int dx = 0; dx < K; dx++)
          for (int dy = 0; dy < K; dy++) begin
            node_x = CW'(nx); node_y = CW'(ny);
            hdr_dst_x = CW'(dx); hdr_dst_y = CW'(dy);
            hdr_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            hdr_valid = 1'b0;
            check(sel_valid == 1'b1, "R8", sel_valid, 1);
            check(sel_port == expect_port(nx, ny, dx, dy), req_of(nx, ny, dx, dy),
                  sel_port, expect_port(nx, ny, dx, dy));
            check($countones(sel_port) == 1, "R7", $countones(sel_port), 1);
          end
    @(negedge clk);

    // Back-pressure: R9, R10
    node_x = 2'd1; node_y = 2'd1;
    sel_ready = 1'b0;
    hdr_dst_x = 2'd3; hdr_dst_y = 2'd0;
    held = expect_port(1, 1, 3, 0);
    hdr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hdr_dst_x = 2'd1; hdr_dst_y = 2'd0;
    nxt = expect_port(1, 1, 1, 0);
    for (int i = 0; i < 4; i++) begin
      check(hdr_ready == 1'b0, "R10", hdr_ready, 0);
      check(sel_valid == 1'b1 && sel_port == held, "R9", sel_port, held);
      @(posedge clk);
      @(negedge clk);
    end
    sel_ready = 1'b1;
    #0;
    check(hdr_ready == 1'b1, "R10", hdr_ready, 1);
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    check(sel_valid == 1'b1 && sel_port == nxt, "R10", sel_port, nxt);
    @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0, "R10", sel_valid, 0);
    finish_run();
  end
endmodule